// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Registers

This block is the register file that sits between a host or firmware processor and eight transmit DMA channel engines. For each channel it holds a configuration word. The fields of that word drive the channel's run mode, its request-enable bit and its two interrupt-condition selectors. The block also keeps a per-channel credit counter and a per-channel buffer status view.

A shared status word collects the buffer-empty and no-pending-request flags of all channels, so software can poll for idle after it stops a channel. A sticky error register gathers the following:
- internal address faults;
- dword-count faults;
- start commands that arrive while a channel's request buffer is still occupied;
- credit mismatches, where the transmit FIFO reports full while the channel's credit counter is not zero.

Software clears each error bit by writing a one to it. Reads return data one cycle after the request.

Top module: `txd_csr`

## Requirements
- R1: After reset every configuration word, every credit counter and the error register are zero, all per-channel outputs are zero, and the read data is zero.
- R2: The configuration word of channel c is at address 0x20*c. Bits 31:30 drive `chan_mode` (0 off or pause, 1 pause at end of frame, 2 run), bit 3 drives `chan_req_en`, bits 21:20 drive `chan_host_irq` and bits 23:22 drive `chan_cpu_irq`. All other bits read as zero.
- R3: When `rd_en` is high at a clock edge, `rdata` carries the addressed register from that edge on, and holds it until the next read.
- R4: The shared status word at 0x100 shows `buf_empty[c]` at bit 24+c and `no_pend[c]` at bit 16+c. Its other bits read zero.
- R5: The buffer status word of channel c at 0x20*c+8 shows buffers-empty at bit 0, no-pending at bit 1, and idle (both set) at bit 2.
- R6: The credit counter of channel c reads at 0x20*c+4. Each write there adds one and each `dma_grant[c]` pulse subtracts one. A write and a grant in the same cycle leave it unchanged. It stays at zero when decremented at zero and stays at its maximum (255 by default) when incremented at the maximum.
- R7: The error register is at 0x104. An `addr_err_evt` pulse sets bit 31 and a `dword_err_evt` pulse sets bit 30. Every error bit stays set until it is cleared.
- R8: A `start_busy_evt[c]` pulse sets error bit 9+c.
- R9: `fifo_full[c]` sets error bit c when channel c's credit counter is nonzero in that cycle. When the counter is zero, the flag does not set the bit.
- R10: Writing a one to an error bit clears it and writing a zero leaves it. When a set event and a clearing write hit the same bit in one cycle, the bit ends up set.
- R11: Writes to the status word, to unused offsets inside a channel window, or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| buf_empty | input | 8 | Per-channel buffers-empty flag from the engines |
| no_pend | input | 8 | Per-channel no-pending-request flag from the engines |
| dma_grant | input | 8 | Per-channel granted DMA request pulse |
| fifo_full | input | 8 | Per-channel transmit FIFO full indication |
| start_busy_evt | input | 8 | Per-channel start-while-occupied event |
| addr_err_evt | input | 1 | Internal memory address fault event |
| dword_err_evt | input | 1 | Wrong dword count from host event |
| chan_mode | output | 16 | Two-bit run mode per channel |
| chan_req_en | output | 8 | Internal request enable per channel |
| chan_host_irq | output | 16 | Two-bit host interrupt condition per channel |
| chan_cpu_irq | output | 16 | Two-bit internal processor interrupt condition per channel |

## Verification
The hardest situations to reach from the ports are the collisions. One is a set event and a one-to-clear write landing on the same error bit in the same cycle. Another is a credit write and a grant landing together. The stimulus drives both strobes at the same falling edge, so the design samples them at one rising edge, and then reads the register back.

The credit ceiling needs a long run of credit writes, so the bench issues several hundred writes to one channel. The credit-mismatch rule is probed twice: once with the counter at zero, where no bit may be set, and once after a single credit write, where the bit must be set.

// File: rtl/txd_csr_pkg.sv
package txd_csr_pkg;
  localparam int REG_W      = 32;
  localparam int STRIDE     = 32;
  localparam int OFF_CFG    = 0;
  localparam int OFF_CRED   = 4;
  localparam int OFF_BSTS   = 8;
  localparam int ADDR_STAT  = 'h100;
  localparam int ADDR_ERR   = 'h104;
  localparam int ERR_ADDR_B = 31;
  localparam int ERR_DW_B   = 30;
  localparam int ERR_BUSY_B = 9;
  localparam int STAT_EMP_B = 24;
  localparam int STAT_NPD_B = 16;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_PAUSE_EOF = 2'd1,
    MODE_RUN       = 2'd2,
    MODE_RSVD      = 2'd3
  } chan_mode_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] cpu_irq;
    logic [1:0] host_irq;
    logic       req_en;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    chan_cfg_t c;
    c.mode     = w[31:30];
    c.cpu_irq  = w[23:22];
    c.host_irq = w[21:20];
    c.req_en   = w[3];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] word_from_cfg(input chan_cfg_t c);
    logic [REG_W-1:0] w;
    w        = '0;
    w[31:30] = c.mode;
    w[23:22] = c.cpu_irq;
    w[21:20] = c.host_irq;
    w[3]     = c.req_en;
    return w;
  endfunction
endpackage

// File: rtl/txd_chan_regs.sv
module txd_chan_regs
  import txd_csr_pkg::*;
#(
  parameter int CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cred_we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              grant,
  input  logic              fifo_full,
  output chan_cfg_t         cfg,
  output logic [CRED_W-1:0] credit,
  output logic              mismatch
);
  localparam logic [CRED_W-1:0] CRED_MAX = {CRED_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (cfg_we) cfg <= cfg_from_word(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit <= '0;
    end else if (cred_we && !grant) begin
      if (credit != CRED_MAX) credit <= credit + 1'b1;
    end else if (grant && !cred_we) begin
      if (credit != '0) credit <= credit - 1'b1;
    end
  end

  assign mismatch = fifo_full && (credit != '0);

  assert_credit_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (grant && !cred_we && credit == '0) |=> credit == '0);
  assert_credit_inc_R6: assert property (@(posedge clk) disable iff (rst)
    (cred_we && !grant && credit != CRED_MAX) |=> credit == CRED_W'($past(credit) + 1'b1));
  assert_credit_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cred_we && grant) |=> $stable(credit));
endmodule

// File: rtl/txd_err_bank.sv
module txd_err_bank
  import txd_csr_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_vec,
  input  logic             clr_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] err
);
  localparam logic [REG_W-1:0] CH_MASK = REG_W'((64'd1 << N_CH) - 64'd1);
  localparam logic [REG_W-1:0] IMPL =
    (REG_W'(1) << ERR_ADDR_B) | (REG_W'(1) << ERR_DW_B) |
    (CH_MASK << ERR_BUSY_B) | CH_MASK;

  logic [REG_W-1:0] clr_vec;
  assign clr_vec = clr_we ? wdata : '0;

  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : g_bit
      if (IMPL[b]) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) err[b] <= 1'b0;
          else if (set_vec[b]) err[b] <= 1'b1;
          else if (clr_vec[b]) err[b] <= 1'b0;
        end
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
          set_vec[b] |=> err[b]);
        assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
          (clr_vec[b] && !set_vec[b]) |=> !err[b]);
        assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
          (err[b] && !clr_vec[b]) |=> err[b]);
      end else begin : g_dead
        assign err[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/txd_csr.sv
module txd_csr
  import txd_csr_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 9,
  parameter int CRED_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic [N_CH-1:0]     buf_empty,
  input  logic [N_CH-1:0]     no_pend,
  input  logic [N_CH-1:0]     dma_grant,
  input  logic [N_CH-1:0]     fifo_full,
  input  logic [N_CH-1:0]     start_busy_evt,
  input  logic                addr_err_evt,
  input  logic                dword_err_evt,
  output logic [2*N_CH-1:0]   chan_mode,
  output logic [N_CH-1:0]     chan_req_en,
  output logic [2*N_CH-1:0]   chan_host_irq,
  output logic [2*N_CH-1:0]   chan_cpu_irq
);
  chan_cfg_t         cfg    [N_CH];
  logic [CRED_W-1:0] credit [N_CH];
  logic [N_CH-1:0]   cfg_we, cred_we, mismatch;
  logic [REG_W-1:0]  err_q, set_vec, rd_next;
  logic              err_we;

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_ch
      assign cfg_we[c]  = wr_en && (addr == ADDR_W'(c*STRIDE + OFF_CFG));
      assign cred_we[c] = wr_en && (addr == ADDR_W'(c*STRIDE + OFF_CRED));

      txd_chan_regs #(.CRED_W(CRED_W)) u_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we[c]), .cred_we(cred_we[c]),
        .wdata(wdata), .grant(dma_grant[c]), .fifo_full(fifo_full[c]),
        .cfg(cfg[c]), .credit(credit[c]), .mismatch(mismatch[c]));

      assign chan_mode[2*c +: 2]     = cfg[c].mode;
      assign chan_req_en[c]          = cfg[c].req_en;
      assign chan_host_irq[2*c +: 2] = cfg[c].host_irq;
      assign chan_cpu_irq[2*c +: 2]  = cfg[c].cpu_irq;
    end
  endgenerate

  assign err_we = wr_en && (addr == ADDR_W'(ADDR_ERR));

  always_comb begin
    set_vec             = '0;
    set_vec[ERR_ADDR_B] = addr_err_evt;
    set_vec[ERR_DW_B]   = dword_err_evt;
    for (int i = 0; i < N_CH; i++) begin
      set_vec[ERR_BUSY_B + i] = start_busy_evt[i];
      set_vec[i]              = mismatch[i];
    end
  end

  txd_err_bank #(.N_CH(N_CH)) u_err (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_we(err_we),
    .wdata(wdata), .err(err_q));

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr == ADDR_W'(i*STRIDE + OFF_CFG))  rd_next = word_from_cfg(cfg[i]);
      if (addr == ADDR_W'(i*STRIDE + OFF_CRED)) rd_next = REG_W'(credit[i]);
      if (addr == ADDR_W'(i*STRIDE + OFF_BSTS))
        rd_next = {29'd0, buf_empty[i] & no_pend[i], no_pend[i], buf_empty[i]};
    end
    if (addr == ADDR_W'(ADDR_STAT)) begin
      for (int i = 0; i < N_CH; i++) begin
        rd_next[STAT_EMP_B + i] = buf_empty[i];
        rd_next[STAT_NPD_B + i] = no_pend[i];
      end
    end
    if (addr == ADDR_W'(ADDR_ERR)) rd_next = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  assert_mode_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we == '0) |=> $stable(chan_mode) && $stable(chan_req_en));
endmodule

// File: tb/txd_csr_test.sv
module txd_csr_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  buf_empty = '0, no_pend = '0, dma_grant = '0, fifo_full = '0, start_busy_evt = '0;
  logic        addr_err_evt = 0, dword_err_evt = 0;
  logic [15:0] chan_mode, chan_host_irq, chan_cpu_irq;
  logic [7:0]  chan_req_en;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  always #10 clk = ~clk;

  txd_csr uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .buf_empty(buf_empty), .no_pend(no_pend), .dma_grant(dma_grant),
    .fifo_full(fifo_full), .start_busy_evt(start_busy_evt), .addr_err_evt(addr_err_evt),
    .dword_err_evt(dword_err_evt), .chan_mode(chan_mode), .chan_req_en(chan_req_en),
    .chan_host_irq(chan_host_irq), .chan_cpu_irq(chan_cpu_irq));

  // monitor: pops expected read data one edge after each read strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s read: actual %08h expected %08h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
    rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s port: actual %08h expected %08h", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(32'(rdata), 0, "R1");
    chk(32'(chan_mode), 0, "R1");
    chk(32'(chan_req_en), 0, "R1");
    rd(9'h060, 0, "R1");
    rd(9'h104, 0, "R1");
    rd(9'h024, 0, "R1");

    // R2 configuration words
    wr(9'h060, 32'hFFFF_FFFF);
    wr(9'h0A0, 32'h8050_0008);
    rd(9'h060, 32'hC0F0_0008, "R2");
    rd(9'h0A0, 32'h8050_0008, "R2");
    chk(32'(chan_mode), 32'h0000_08C0, "R2");
    chk(32'(chan_req_en), 32'h28, "R2");
    chk(32'(chan_host_irq), 32'h0000_04C0, "R2");
    chk(32'(chan_cpu_irq), 32'h0000_04C0, "R2");

    // R3 read data holds without a read
    repeat (3) @(negedge clk);
    chk(rdata, 32'h8050_0008, "R3");

    // R4 / R5 status views
    buf_empty = 8'hA5; no_pend = 8'h3C;
    rd(9'h100, 32'hA53C_0000, "R4");
    rd(9'h008, 32'h1, "R5");
    rd(9'h048, 32'h7, "R5");
    rd(9'h068, 32'h2, "R5");

    // R6 credit counting
    repeat (3) wr(9'h024, 0);
    rd(9'h024, 3, "R6");
    dma_grant = 8'h02; @(negedge clk); @(negedge clk); dma_grant = 0;
    rd(9'h024, 1, "R6");
    dma_grant = 8'h02; wr(9'h024, 0); dma_grant = 0;
    rd(9'h024, 1, "R6");
    dma_grant = 8'h02; repeat (3) @(negedge clk); dma_grant = 0;
    rd(9'h024, 0, "R6");
    for (int i = 0; i < 260; i++) wr(9'h0C4, 0);
    rd(9'h0C4, 255, "R6");

    // R9 credit mismatch
    fifo_full = 8'h02; @(negedge clk); fifo_full = 0;
    rd(9'h104, 0, "R9");
    wr(9'h024, 0);
    fifo_full = 8'h02; @(negedge clk); fifo_full = 0;
    rd(9'h104, 32'h2, "R9");

    // R7 / R8 sticky events
    addr_err_evt = 1; dword_err_evt = 1; start_busy_evt = 8'h80;
    @(negedge clk);
    addr_err_evt = 0; dword_err_evt = 0; start_busy_evt = 0;
    repeat (2) @(negedge clk);
    rd(9'h104, 32'hC001_0002, "R7");
    rd(9'h104, 32'hC001_0002, "R8");

    // R10 write one to clear, zero leaves, set wins
    wr(9'h104, 32'h4000_0000);
    rd(9'h104, 32'h8001_0002, "R10");
    wr(9'h104, 32'h0);
    rd(9'h104, 32'h8001_0002, "R10");
    addr_err_evt = 1; wr(9'h104, 32'h8000_0000); addr_err_evt = 0;
    rd(9'h104, 32'h8001_0002, "R10");
    wr(9'h104, 32'hFFFF_FFFF);
    rd(9'h104, 0, "R10");

    // R11 writes with no effect
    wr(9'h100, 32'hFFFF_FFFF);
    rd(9'h100, 32'hA53C_0000, "R11");
    wr(9'h00C, 32'hFFFF_FFFF);
    wr(9'h1F0, 32'hFFFF_FFFF);
    rd(9'h000, 0, "R11");
    rd(9'h1F0, 0, "R11");
    chk(32'(chan_mode), 32'h0000_08C0, "R11");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule